// File: doc/BRIEF.md
# Dual-Channel Cascadable 8-Bit Compare Timer

Two 8-bit up-counting timer channels behind a small register bus. Each channel advances on a tick chosen from a shared prescaler (system clock divided by 8, 64 or 8192), from rising edges of an external clock pin, or from a cascade source. Every tick is compared against two per-channel compare values, A and B. A match can restart the count, raise a sticky interrupt flag and move the channel's waveform output through a two-state output machine. Channel 1 overflows can drive channel 0, which gives one 16-bit counter with channel 0 as the high byte. Channel 0 compare-A events can also be counted by channel 1. Every channel 0 compare-A event sends a single-cycle pulse to start a converter.

The block leaves reset in a halted state. While halted the prescaler and both counters are frozen, channel registers read as zero and ignore writes. Only the run register answers. Software writes 1 to the run register to enter the running state, then configures the channels.

Register map (4-bit address, 8-bit data): address 0 is the run register (bit 0). Channel c occupies addresses 8c+1 to 8c+6: 1 control, 2 output actions, 3 status, 4 count, 5 compare A, 6 compare B. Control fields: bits 2:0 tick source (0 none, 1 divide-by-8, 2 divide-by-64, 3 divide-by-8192, 4 external clock, 5 cascade, 6 and 7 none); bits 4:3 restart condition (0 none, 1 on match A, 2 on match B, 3 while the external reset input is high); bit 5 match-A interrupt enable, bit 6 match-B enable, bit 7 overflow enable. Output action register: bits 1:0 action on match A, bits 3:2 action on match B, each coded 0 keep, 1 drive low, 2 drive high, 3 invert. Status: bit 0 match A, bit 1 match B, bit 2 overflow; writing 1 to a bit clears it.

Top module: `tmr8x2`

## Requirements
- R1: After reset the block is halted. The run register (address 0, bit 0) reads 0. Channel registers read 0 while halted and writes to them are dropped, so compare A and B still read 0xFF after the block is started.
- R2: Tick source codes 1, 2 and 3 advance the count exactly once per 8, 64 and 8192 system clocks. Code 0 never advances it.
- R3: Tick source code 4 advances the count by one for each rising edge on ext_clk.
- R4: A match occurs when a tick arrives while the count equals the compare value. With restart code 1 (A) or 2 (B) that tick loads 0 instead of count+1.
- R5: With restart code 3 the count is held at 0 while ext_rst is high and resumes counting from 0 once it falls.
- R6: On a match, the channel output follows the 2-bit action for that compare (0 keep, 1 low, 2 high, 3 invert). With no match the output does not change.
- R7: When matches A and B fall on the same tick, only the action for A is applied.
- R8: Status bits 0 and 1 are set by matches A and B and cleared by writing 1. An interrupt line is high only while its flag and its enable (control bits 5 and 6) are both set.
- R9: A tick at count 0xFF wraps the count to 0 and sets status bit 2. irq_ovf follows it when control bit 7 is set.
- R10: Channel 0 with source code 5 advances once per overflow of channel 1, which forms a 16-bit counter.
- R11: Channel 1 with source code 5 advances once per channel 0 match-A event.
- R12: adc_trig pulses high for exactly one cycle per channel 0 match-A event.
- R13: Writing 0 to the run register halts counting. Register contents are kept, and edges seen while halted are not counted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata the next cycle |
| bus_rdata | output | 8 | Registered read data |
| ext_clk | input | 1 | External count clock, asynchronous |
| ext_rst | input | 1 | External counter restart, asynchronous |
| tout | output | 2 | Waveform output per channel |
| irq_cma | output | 2 | Match-A interrupt per channel |
| irq_cmb | output | 2 | Match-B interrupt per channel |
| irq_ovf | output | 2 | Overflow interrupt per channel |
| adc_trig | output | 1 | Converter start pulse from channel 0 match A |

## Verification
The prescaler phase is hidden from the ports, and it keeps moving the whole time the bench is configuring. The divide rates are therefore checked by reading the count twice, exactly N clocks apart. The difference must be exactly N divided by the rate, whatever the phase. The cascade modes and the halt-then-restart case depend on events that occur in the block, not on any bus write. The stimulus reaches them by pacing ext_clk slowly enough that each edge is one tick: channel 1 is walked through 0xFE to 0x01, channel 0 is walked around a compare of 1, and edges are applied while the block is halted.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DW     = 8;
    localparam int AW     = 4;
    localparam int NCH    = 2;
    localparam int PRE_W  = 13;
    localparam int N_DIV  = 3;
    localparam int DIV_TAP [N_DIV] = '{2, 5, 12};
    localparam int SYNC_N = 2;

    localparam logic [2:0] OFF_CTL = 3'd1;
    localparam logic [2:0] OFF_OUT = 3'd2;
    localparam logic [2:0] OFF_STS = 3'd3;
    localparam logic [2:0] OFF_CNT = 3'd4;
    localparam logic [2:0] OFF_CPA = 3'd5;
    localparam logic [2:0] OFF_CPB = 3'd6;

    localparam logic [2:0] CK_D8   = 3'd1;
    localparam logic [2:0] CK_D64  = 3'd2;
    localparam logic [2:0] CK_D8K  = 3'd3;
    localparam logic [2:0] CK_EXT  = 3'd4;
    localparam logic [2:0] CK_CAS  = 3'd5;

    typedef enum logic [1:0] {CL_NONE, CL_A, CL_B, CL_EXT} clr_e;
    typedef enum logic [1:0] {ACT_KEEP, ACT_LO, ACT_HI, ACT_TGL} act_e;
    typedef enum logic {OUT_LO, OUT_HI} out_st_e;
    typedef enum logic {MS_HALT, MS_RUN} run_st_e;

    function automatic out_st_e out_next(out_st_e cur, act_e a);
        out_st_e n;
        unique case (a)
            ACT_KEEP: n = cur;
            ACT_LO:   n = OUT_LO;
            ACT_HI:   n = OUT_HI;
            ACT_TGL:  n = (cur == OUT_HI) ? OUT_LO : OUT_HI;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [N_DIV-1:0] div_en
);
    logic [PRE_W-1:0] pre_q;
    logic [N_DIV-1:0] tap_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (run)
            pre_q <= pre_q + PRE_W'(1);
    end

    for (genvar i = 0; i < N_DIV; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (!rst_n)
                tap_q[i] <= 1'b0;
            else
                tap_q[i] <= pre_q[DIV_TAP[i]];
        end
        assign div_en[i] = pre_q[DIV_TAP[i]] & ~tap_q[i];
    end
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], d};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign lvl  = sh_q[STAGES-1];
    assign rise = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int W = DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [N_DIV-1:0] div_en,
    input  logic             ext_tick,
    input  logic             cas_tick,
    input  logic             ext_clr,
    input  logic             wr_en,
    input  logic [2:0]       off,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rd_data,
    output logic             tout,
    output logic             irq_a,
    output logic             irq_b,
    output logic             irq_ovf,
    output logic             evt_a,
    output logic             evt_b,
    output logic             evt_ovf,
    output logic [W-1:0]     cnt_o
);
    logic [7:0]   ctl_q;
    logic [3:0]   act_q;
    logic [2:0]   sts_q, sts_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] cpa_q, cpb_q;
    out_st_e      out_q, out_d;

    logic [2:0] ck_sel;
    clr_e       clr_sel;
    logic       src, tick, hold, hit_a, hit_b, wrap;

    assign ck_sel  = ctl_q[2:0];
    assign clr_sel = clr_e'(ctl_q[4:3]);

    // tick source selection
    always_comb begin
        case (ck_sel)
            CK_D8:   src = div_en[0];
            CK_D64:  src = div_en[1];
            CK_D8K:  src = div_en[2];
            CK_EXT:  src = ext_tick;
            CK_CAS:  src = cas_tick;
            default: src = 1'b0;
        endcase
    end

    assign hold    = run && (clr_sel == CL_EXT) && ext_clr;
    assign tick    = run && src && !hold;
    assign hit_a   = (cnt_q == cpa_q);
    assign hit_b   = (cnt_q == cpb_q);
    assign evt_a   = tick && hit_a;
    assign evt_b   = tick && hit_b;
    assign evt_ovf = tick && (cnt_q == '1);
    assign wrap    = ((clr_sel == CL_A) && hit_a) || ((clr_sel == CL_B) && hit_b);

    always_comb begin
        cnt_d = cnt_q;
        if (wr_en && off == OFF_CNT)
            cnt_d = wdata;
        else if (hold)
            cnt_d = '0;
        else if (tick)
            cnt_d = wrap ? '0 : cnt_q + W'(1);
    end

    always_comb begin
        sts_d = sts_q;
        if (wr_en && off == OFF_STS)
            sts_d = sts_q & ~wdata[2:0];
        sts_d = sts_d | {evt_ovf, evt_b, evt_a};
    end

    // output waveform machine: A has priority over B
    always_comb begin
        out_d = out_q;
        if (evt_a)
            out_d = out_next(out_q, act_e'(act_q[1:0]));
        else if (evt_b)
            out_d = out_next(out_q, act_e'(act_q[3:2]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= OUT_LO;
        else
            out_q <= out_d;
    end

    always_comb begin
        unique case (out_q)
            OUT_LO: tout = 1'b0;
            OUT_HI: tout = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            act_q <= '0;
            sts_q <= '0;
            cnt_q <= '0;
            cpa_q <= '1;
            cpb_q <= '1;
        end else begin
            cnt_q <= cnt_d;
            sts_q <= sts_d;
            if (wr_en && off == OFF_CTL) ctl_q <= wdata[7:0];
            if (wr_en && off == OFF_OUT) act_q <= wdata[3:0];
            if (wr_en && off == OFF_CPA) cpa_q <= wdata;
            if (wr_en && off == OFF_CPB) cpb_q <= wdata;
        end
    end

    always_comb begin
        case (off)
            OFF_CTL: rd_data = W'(ctl_q);
            OFF_OUT: rd_data = W'(act_q);
            OFF_STS: rd_data = W'(sts_q);
            OFF_CNT: rd_data = cnt_q;
            OFF_CPA: rd_data = cpa_q;
            OFF_CPB: rd_data = cpb_q;
            default: rd_data = '0;
        endcase
    end

    assign irq_a   = sts_q[0] & ctl_q[5];
    assign irq_b   = sts_q[1] & ctl_q[6];
    assign irq_ovf = sts_q[2] & ctl_q[7];
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/tmr8x2.sv
module tmr8x2
    import tmr_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    input  logic           bus_wr,
    input  logic           bus_rd,
    output logic [DW-1:0]  bus_rdata,
    input  logic           ext_clk,
    input  logic           ext_rst,
    output logic [NCH-1:0] tout,
    output logic [NCH-1:0] irq_cma,
    output logic [NCH-1:0] irq_cmb,
    output logic [NCH-1:0] irq_ovf,
    output logic           adc_trig
);
    run_st_e st_q, st_d;
    logic    run, go_req, stop_req;

    logic [N_DIV-1:0]        div_en;
    logic                    ext_lvl_unused, ext_rise, rst_lvl, rst_rise_unused;
    logic [NCH-1:0]          evt_a, evt_b, evt_ovf, cas_w, wr_ch;
    logic [NCH-1:0][DW-1:0]  rd_ch, cnt_w;
    logic                    c1_ovf_q, c0_a_q;

    assign go_req   = bus_wr && (bus_addr == '0) && bus_wdata[0];
    assign stop_req = bus_wr && (bus_addr == '0) && !bus_wdata[0];

    // run-state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= MS_HALT;
        else
            st_q <= st_d;
    end

    // run-state transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MS_HALT: if (go_req)   st_d = MS_RUN;
            MS_RUN:  if (stop_req) st_d = MS_HALT;
        endcase
    end

    // run-state outputs
    always_comb begin
        unique case (st_q)
            MS_HALT: run = 1'b0;
            MS_RUN:  run = 1'b1;
        endcase
    end

    tmr_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div_en (div_en)
    );

    tmr_sync #(.STAGES(SYNC_N)) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_clk),
        .lvl   (ext_lvl_unused),
        .rise  (ext_rise)
    );

    tmr_sync #(.STAGES(SYNC_N)) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_rst),
        .lvl   (rst_lvl),
        .rise  (rst_rise_unused)
    );

    // cascade pulses are registered to break the loop between channels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c1_ovf_q <= 1'b0;
            c0_a_q   <= 1'b0;
            adc_trig <= 1'b0;
        end else begin
            c1_ovf_q <= evt_ovf[1];
            c0_a_q   <= evt_a[0];
            adc_trig <= evt_a[0];
        end
    end

    assign cas_w[0] = c1_ovf_q;
    assign cas_w[1] = c0_a_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign wr_ch[c] = bus_wr && run && (bus_addr[AW-1] == 1'(c))
                          && (bus_addr[2:0] != 3'd0);
        tmr_chan #(.W(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .div_en   (div_en),
            .ext_tick (ext_rise),
            .cas_tick (cas_w[c]),
            .ext_clr  (rst_lvl),
            .wr_en    (wr_ch[c]),
            .off      (bus_addr[2:0]),
            .wdata    (bus_wdata),
            .rd_data  (rd_ch[c]),
            .tout     (tout[c]),
            .irq_a    (irq_cma[c]),
            .irq_b    (irq_cmb[c]),
            .irq_ovf  (irq_ovf[c]),
            .evt_a    (evt_a[c]),
            .evt_b    (evt_b[c]),
            .evt_ovf  (evt_ovf[c]),
            .cnt_o    (cnt_w[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (!bus_rd)
            bus_rdata <= '0;
        else if (bus_addr == '0)
            bus_rdata <= DW'(run);
        else if (run)
            bus_rdata <= rd_ch[bus_addr[AW-1]];
        else
            bus_rdata <= '0;
    end
endmodule

// File: rtl/tmr8x2_chk.sv
module tmr8x2_chk
    import tmr_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   run,
    input logic                   bus_rd,
    input logic [AW-1:0]          bus_addr,
    input logic [DW-1:0]          bus_rdata,
    input logic [NCH-1:0][DW-1:0] cnt_w,
    input logic [NCH-1:0]         evt_a,
    input logic [NCH-1:0]         evt_b,
    input logic [NCH-1:0]         tout,
    input logic                   adc_trig
);
    p_halt_freeze_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_w));

    p_halt_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !run && bus_addr != '0) |=> (bus_rdata == '0));

    p_trig_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |=> !adc_trig);

    p_out0_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_a[0] || evt_b[0]) |=> $stable(tout[0]));

    p_out1_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_a[1] || evt_b[1]) |=> $stable(tout[1]));
endmodule

bind tmr8x2 tmr8x2_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cnt_w     (cnt_w),
    .evt_a     (evt_a),
    .evt_b     (evt_b),
    .tout      (tout),
    .adc_trig  (adc_trig)
);

// File: tb/tmr8x2_bench.sv
module tmr8x2_bench;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;
    logic       ext_rst = 1'b0;
    logic [1:0] tout, irq_cma, irq_cmb, irq_ovf;
    logic       adc_trig;

    int total = 0;
    int bad = 0;
    int trig_n = 0;
    logic rd_q = 1'b0;
    logic trig_q = 1'b0;

    typedef struct {
        logic [7:0] exp;
        bit         chk;
        string      tag;
    } item_t;
    item_t sb[$];

    always #(CLK_NS / 2) clk = ~clk;

    tmr8x2 u_tmr8x2 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ext_clk(ext_clk), .ext_rst(ext_rst), .tout(tout), .irq_cma(irq_cma),
        .irq_cmb(irq_cmb), .irq_ovf(irq_ovf), .adc_trig(adc_trig)
    );

    task automatic check(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read items and compares
    always @(posedge clk) rd_q <= bus_rd;
    always @(negedge clk) begin
        if (rd_q && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            if (it.chk) check(it.tag, int'(bus_rdata), int'(it.exp));
        end
        if (adc_trig) trig_n++;
        if (adc_trig && trig_q) check("R12 trigger width", 2, 1);
        trig_q = adc_trig;
    end

    task automatic wr(logic [3:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(logic [3:0] a, logic [7:0] e, string tag);
        item_t it;
        it.exp = e; it.chk = 1'b1; it.tag = tag;
        sb.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(logic [3:0] a, output logic [7:0] v);
        item_t it;
        it.exp = '0; it.chk = 1'b0; it.tag = "";
        sb.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1;
            repeat (4) @(negedge clk);
            ext_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    // rate check: two reads exactly gap cycles apart
    task automatic rate(logic [7:0] code, int gap, int exp_diff, string tag);
        logic [7:0] v;
        wr(4'd1, code);
        wr(4'd4, 8'h00);
        peek(4'd4, v);
        repeat (gap - 1) @(negedge clk);
        rd_expect(4'd4, v + 8'(exp_diff), tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check("watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: halted after reset
        rd_expect(4'd0, 8'h00, "R1 run reg after reset");
        rd_expect(4'd4, 8'h00, "R1 count read halted");
        check("R1 tout reset", int'(tout), 0);
        check("R1 adc_trig reset", int'(adc_trig), 0);
        wr(4'd5, 8'h12);
        wr(4'd0, 8'h01);
        rd_expect(4'd0, 8'h01, "R1 run reg after start");
        rd_expect(4'd5, 8'hFF, "R1 halted write dropped");
        rd_expect(4'd14, 8'hFF, "R1 ch1 compare B reset");

        // R2: prescaler rates
        rate(8'h01, 80, 10, "R2 divide by 8");
        rate(8'h02, 640, 10, "R2 divide by 64");
        rate(8'h03, 16384, 2, "R2 divide by 8192");
        rate(8'h00, 100, 0, "R2 source off");

        // R3: external clock
        wr(4'd1, 8'h04);
        wr(4'd4, 8'h00);
        pulses(5);
        rd_expect(4'd4, 8'h05, "R3 ext clock edges");

        // R4: restart on match A, then on match B
        wr(4'd5, 8'h03);
        wr(4'd6, 8'h01);
        wr(4'd1, 8'h0C);
        wr(4'd4, 8'h00);
        pulses(4);
        rd_expect(4'd4, 8'h00, "R4 restart on A");
        pulses(2);
        rd_expect(4'd4, 8'h02, "R4 count after restart");
        wr(4'd1, 8'h14);
        wr(4'd4, 8'h00);
        pulses(3);
        rd_expect(4'd4, 8'h01, "R4 restart on B");

        // R6: set on A, clear on B (channel 1)
        wr(4'd13, 8'h02);
        wr(4'd14, 8'h05);
        wr(4'd10, 8'h06);
        wr(4'd9, 8'h14);
        wr(4'd12, 8'h00);
        pulses(3);
        check("R6 high after A", int'(tout[1]), 1);
        pulses(3);
        check("R6 low after B", int'(tout[1]), 0);
        rd_expect(4'd12, 8'h00, "R4 ch1 restart on B");
        wr(4'd10, 8'h03);
        wr(4'd13, 8'h01);
        wr(4'd9, 8'h0C);
        wr(4'd12, 8'h00);
        pulses(2);
        check("R6 invert on A", int'(tout[1]), 1);
        pulses(2);
        check("R6 invert back", int'(tout[1]), 0);

        // R7: A and B same tick
        wr(4'd13, 8'h02);
        wr(4'd14, 8'h02);
        wr(4'd10, 8'h06);
        wr(4'd12, 8'h00);
        pulses(3);
        check("R7 A wins over B", int'(tout[1]), 1);

        // R8: flags and interrupt enables
        rd_expect(4'd11, 8'h03, "R8 ch1 flags");
        check("R8 irq A disabled", int'(irq_cma[1]), 0);
        wr(4'd9, 8'h2C);
        @(negedge clk);
        check("R8 irq A enabled", int'(irq_cma[1]), 1);
        check("R8 irq B disabled", int'(irq_cmb[1]), 0);
        wr(4'd11, 8'h01);
        rd_expect(4'd11, 8'h02, "R8 write one clears A");
        check("R8 irq A cleared", int'(irq_cma[1]), 0);

        // R9: overflow
        wr(4'd3, 8'h07);
        wr(4'd1, 8'h84);
        wr(4'd4, 8'hFE);
        pulses(2);
        rd_expect(4'd4, 8'h00, "R9 wrap to zero");
        rd_expect(4'd3, 8'h04, "R9 overflow flag");
        check("R9 irq overflow", int'(irq_ovf[0]), 1);

        // R5: external restart
        wr(4'd1, 8'h1C);
        wr(4'd4, 8'h40);
        ext_rst = 1'b1;
        repeat (5) @(negedge clk);
        rd_expect(4'd4, 8'h00, "R5 held at zero");
        pulses(2);
        rd_expect(4'd4, 8'h00, "R5 edges ignored while held");
        ext_rst = 1'b0;
        repeat (5) @(negedge clk);
        pulses(2);
        rd_expect(4'd4, 8'h02, "R5 resumes from zero");

        // R13: halt keeps state, drops edges
        wr(4'd1, 8'h04);
        wr(4'd4, 8'h10);
        wr(4'd0, 8'h00);
        pulses(3);
        rd_expect(4'd0, 8'h00, "R13 run reg halted");
        rd_expect(4'd4, 8'h00, "R1 read zero while halted");
        wr(4'd0, 8'h01);
        rd_expect(4'd4, 8'h10, "R13 count kept");

        // R10: 16-bit chain
        wr(4'd9, 8'h04);
        wr(4'd12, 8'hFE);
        wr(4'd1, 8'h05);
        wr(4'd4, 8'h00);
        pulses(3);
        rd_expect(4'd4, 8'h01, "R10 high byte");
        rd_expect(4'd12, 8'h01, "R10 low byte");

        // R11 and R12: count channel 0 matches
        wr(4'd4, 8'h00);
        wr(4'd5, 8'h01);
        wr(4'd1, 8'h0C);
        wr(4'd9, 8'h05);
        wr(4'd12, 8'h00);
        trig_n = 0;
        pulses(6);
        rd_expect(4'd12, 8'h03, "R11 match count");
        check("R12 trigger pulses", trig_n, 3);

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule